// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the timing skeleton of a serial audio port: a bit clock, a frame sync pulse and a one-cycle bit-slot strobe. A serial shifter elsewhere uses the strobe to launch and capture data bits. In master mode all three come from one system clock through a programmable divider and a frame counter, and the bit clock and frame sync pins are driven. In slave mode both pins are inputs. The block then only resynchronises them to the system clock and turns them into the same strobe and frame indication.

Configuration arrives on static inputs. It is copied into a shadow register on every cycle in which the block is disabled and is frozen while the block runs. The divider, period and width fields are all stored as the wanted count minus one. A short-pulse mode sets the pulse one bit slot shorter than the frame. Bit clock polarity and frame sync polarity are chosen independently.

Top module: `afs_frame_sync_gen`

## Requirements
- R1: In master mode each bit slot lasts (divider field + 1) system clocks. With clock inversion off, the bit clock is low for the first floor(ratio_field/2)+1 cycles of a slot and high for the rest. The slot strobe is high for exactly the first cycle of every slot.
- R2: A divider field of 0 behaves as a field of 1, giving a ratio of 2.
- R3: A frame lasts (period field + 1) slots. The frame pulse is active in the first (width field + 1) slots of every frame, and frame_act is high in exactly those slots.
- R4: A width field greater than or equal to the period field is clamped, so the pulse covers all but the last slot of the frame. A period field of 0 behaves as a field of 1.
- R5: With short-pulse mode set, the pulse covers all but the last slot of the frame, whatever the width field holds.
- R6: With cfg_clk_inv=0, the bit clock falls at slot start. With cfg_clk_inv=1, it is inverted. With cfg_fs_inv=0, fsync_o is active low. With cfg_fs_inv=1, fsync_o is active high. The two selections are independent.
- R7: bclk_oe and fsync_oe are 1 in master mode and 0 in slave mode. In slave mode, bclk_o stays at cfg_clk_inv and fsync_o stays at its inactive level.
- R8: While en is low, slot_stb and frame_act are 0, bclk_o rests at cfg_clk_inv and fsync_o is inactive. Configuration inputs are taken only while en is low, and changing them while en is high has no effect on the running pattern.
- R9: In the first cycle after en is sampled high, the block is in slot 0 of a fresh frame, with the strobe and the frame pulse both active. Disabling and re-enabling mid-frame restarts from slot 0.
- R10: In slave mode, slot_stb pulses for one cycle, two cycles after the launch edge of bclk_i. The launch edge is falling when cfg_clk_inv=0 and rising when cfg_clk_inv=1. frame_act follows the active level of fsync_i with the same two-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; configuration is sampled while low |
| cfg_div | input | DIV_W (8) | Clock ratio minus one |
| cfg_per | input | SLOT_W (8) | Frame length in slots minus one |
| cfg_wid | input | SLOT_W (8) | Pulse width in slots minus one |
| cfg_short | input | 1 | Short-pulse mode: width is period minus one slot |
| cfg_master | input | 1 | 1 = generate and drive clock and frame sync |
| cfg_clk_inv | input | 1 | Invert bit clock |
| cfg_fs_inv | input | 1 | 1 = frame sync active high |
| bclk_i | input | 1 | External bit clock in slave mode |
| fsync_i | input | 1 | External frame sync in slave mode |
| bclk_o | output | 1 | Bit clock pin value |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_o | output | 1 | Frame sync pin value |
| fsync_oe | output | 1 | Frame sync output enable |
| slot_stb | output | 1 | One-cycle strobe at each bit-slot start |
| frame_act | output | 1 | Active-high frame indication |

## Verification
The bench goes after the edges of the field arithmetic. It uses a divider of zero, which a naive counter would turn into a stuck clock, and an odd ratio, where an off-by-one in the half-period compare shifts the clock edge. It also uses a width at or beyond the period, which without the clamp would hold the frame sync active for the whole frame and never show a frame boundary. It tries every polarity pair to catch swapped or coupled inversions. It changes configuration mid-run, which exposes a shadow that loads while enabled. It re-enables mid-frame, which exposes counters that resume instead of restarting. In slave mode it checks the exact strobe latency and that no strobe appears on the capture edge, which an edge detector of the wrong sense would produce.

// File: rtl/afs_pkg.sv
`timescale 1ns/1ps
package afs_pkg;
  localparam int DIV_W  = 8;   // clock ratio field width
  localparam int SLOT_W = 8;   // period / width field width
  localparam int SYNC_N = 2;   // resync stages for slave inputs

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [SLOT_W-1:0] per;
    logic [SLOT_W-1:0] wid;
    logic              short_fs;
    logic              master;
    logic              clk_inv;
    logic              fs_inv;
  } afs_cfg_t;
endpackage

// File: rtl/afs_bit_frame_gen.sv
`timescale 1ns/1ps
// Master-mode generator: clock divider, slot counter, frame pulse.
module afs_bit_frame_gen
  import afs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [SLOT_W-1:0] per,
  input  logic [SLOT_W-1:0] wid,
  input  logic              short_fs,
  input  logic              clk_inv,
  input  logic              fs_inv,
  output logic              bclk_pin,
  output logic              fs_pin,
  output logic              fs_act,
  output logic              slot_stb
);
  localparam logic [DIV_W-1:0]  DIV_MIN = DIV_W'(1);
  localparam logic [SLOT_W-1:0] PER_MIN = SLOT_W'(1);

  logic              active_q, active_n;
  logic [DIV_W-1:0]  cnt_q, cnt_n;
  logic [SLOT_W-1:0] bit_q, bit_n;
  logic              bclk_q, bclk_n;
  logic              fsp_q, fsp_n;
  logic              fsa_q, fsa_n;
  logic              stb_q, stb_n;

  logic [DIV_W-1:0]  div_eff;
  logic [SLOT_W-1:0] per_eff, wid_eff;

  // effective fields (minimums and clamp)
  always_comb begin
    div_eff = (div == '0) ? DIV_MIN : div;
    per_eff = (per == '0) ? PER_MIN : per;
    if (short_fs || (wid >= per_eff)) wid_eff = per_eff - PER_MIN;
    else                              wid_eff = wid;
  end

  // next state
  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    bit_n    = bit_q;
    if (!run) begin
      active_n = 1'b0;
      cnt_n    = '0;
      bit_n    = '0;
    end else if (!active_q) begin
      active_n = 1'b1;
      cnt_n    = '0;
      bit_n    = '0;
    end else if (cnt_q >= div_eff) begin
      cnt_n = '0;
      bit_n = (bit_q >= per_eff) ? '0 : bit_q + PER_MIN;
    end else begin
      cnt_n = cnt_q + DIV_MIN;
    end
    bclk_n = (active_n && (cnt_n > (div_eff >> 1))) ^ clk_inv;
    fsa_n  = active_n && (bit_n <= wid_eff);
    fsp_n  = fsa_n ^ ~fs_inv;
    stb_n  = active_n && (cnt_n == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      bclk_q   <= 1'b0;
      fsp_q    <= 1'b1;
      fsa_q    <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      bit_q    <= bit_n;
      bclk_q   <= bclk_n;
      fsp_q    <= fsp_n;
      fsa_q    <= fsa_n;
      stb_q    <= stb_n;
    end
  end

  assign bclk_pin = bclk_q;
  assign fs_pin   = fsp_q;
  assign fs_act   = fsa_q;
  assign slot_stb = stb_q;

  // R9: a fresh start lands on slot 0 with pulse active
  a_r9_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (stb_q && fsa_q));
  // R1: each slot begins at the launch level of the bit clock
  a_r1_launch_level: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (bclk_q == clk_inv));
  // R4: pulse is never active in the last slot of a frame
  a_r4_gap_before_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    fsa_q |-> (bit_q != per_eff));
  // R3: pulse is active in the first slot of each frame
  a_r3_pulse_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && (bit_q == '0)) |-> fsa_q);
endmodule

// File: rtl/afs_ext_sync.sv
`timescale 1ns/1ps
// Slave-mode path: resynchronise external clock and frame sync.
module afs_ext_sync
  import afs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clk_inv,
  input  logic fs_inv,
  input  logic bclk_i,
  input  logic fsync_i,
  output logic slot_stb,
  output logic fs_act
);
  logic [SYNC_N:0]   bs_q, bs_n;   // extra stage for edge detect
  logic [SYNC_N-1:0] fs_q, fs_n;

  always_comb begin
    bs_n[0] = bclk_i ^ clk_inv;       // normalised: launch edge is falling
    fs_n[0] = fsync_i ^ ~fs_inv;      // normalised: active high
  end

  for (genvar i = 1; i <= SYNC_N; i++) begin : g_bs_stage
    assign bs_n[i] = bs_q[i-1];
  end
  for (genvar i = 1; i < SYNC_N; i++) begin : g_fs_stage
    assign fs_n[i] = fs_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_q <= '0;
      fs_q <= '0;
    end else begin
      bs_q <= bs_n;
      fs_q <= fs_n;
    end
  end

  assign slot_stb = en && bs_q[SYNC_N] && !bs_q[SYNC_N-1];
  assign fs_act   = en && fs_q[SYNC_N-1];

  // R10: strobe is a single-cycle pulse
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb |=> !slot_stb);
endmodule

// File: rtl/afs_frame_sync_gen.sv
`timescale 1ns/1ps
module afs_frame_sync_gen
  import afs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [SLOT_W-1:0] cfg_per,
  input  logic [SLOT_W-1:0] cfg_wid,
  input  logic              cfg_short,
  input  logic              cfg_master,
  input  logic              cfg_clk_inv,
  input  logic              cfg_fs_inv,
  input  logic              bclk_i,
  input  logic              fsync_i,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              fsync_o,
  output logic              fsync_oe,
  output logic              slot_stb,
  output logic              frame_act
);
  afs_cfg_t cfg_in, sh_q, sh_n;
  logic     m_run, s_en;
  logic     m_bclk, m_fsp, m_fsa, m_stb;
  logic     s_stb, s_fsa;

  assign cfg_in = '{div: cfg_div, per: cfg_per, wid: cfg_wid,
                    short_fs: cfg_short, master: cfg_master,
                    clk_inv: cfg_clk_inv, fs_inv: cfg_fs_inv};

  // shadow loads only while disabled
  always_comb sh_n = en ? sh_q : cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign m_run = en &&  sh_q.master;
  assign s_en  = en && !sh_q.master;

  afs_bit_frame_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (m_run),
    .div      (sh_q.div),
    .per      (sh_q.per),
    .wid      (sh_q.wid),
    .short_fs (sh_q.short_fs),
    .clk_inv  (sh_q.clk_inv),
    .fs_inv   (sh_q.fs_inv),
    .bclk_pin (m_bclk),
    .fs_pin   (m_fsp),
    .fs_act   (m_fsa),
    .slot_stb (m_stb)
  );

  afs_ext_sync u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (s_en),
    .clk_inv  (sh_q.clk_inv),
    .fs_inv   (sh_q.fs_inv),
    .bclk_i   (bclk_i),
    .fsync_i  (fsync_i),
    .slot_stb (s_stb),
    .fs_act   (s_fsa)
  );

  assign bclk_o    = m_bclk;
  assign fsync_o   = m_fsp;
  assign bclk_oe   = sh_q.master;
  assign fsync_oe  = sh_q.master;
  assign slot_stb  = sh_q.master ? m_stb : s_stb;
  assign frame_act = sh_q.master ? m_fsa : s_fsa;

  // R8: quiet once disabled for a full cycle
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (!slot_stb && !frame_act));
  // R8: configuration frozen while enabled
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(sh_q));
endmodule

// File: tb/tb_afs_frame_sync_gen.sv
`timescale 1ns/1ps
module tb_afs_frame_sync_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] cfg_div, cfg_per, cfg_wid;
  logic       cfg_short, cfg_master, cfg_clk_inv, cfg_fs_inv;
  logic       bclk_i, fsync_i;
  logic       bclk_o, bclk_oe, fsync_o, fsync_oe, slot_stb, frame_act;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // mirror of the programmed configuration
  int m_div, m_per, m_wid;
  bit m_sh, m_ci, m_fi;

  always #2.5 clk = ~clk;

  afs_frame_sync_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_div(cfg_div), .cfg_per(cfg_per), .cfg_wid(cfg_wid),
    .cfg_short(cfg_short), .cfg_master(cfg_master),
    .cfg_clk_inv(cfg_clk_inv), .cfg_fs_inv(cfg_fs_inv),
    .bclk_i(bclk_i), .fsync_i(fsync_i),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .fsync_o(fsync_o),
    .fsync_oe(fsync_oe), .slot_stb(slot_stb), .frame_act(frame_act)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int obs();
    return {28'd0, slot_stb, bclk_o, fsync_o, frame_act};
  endfunction

  // expected {stb,bclk,fsync,frame_act} k cycles after enable
  function automatic int exp_vec(int k);
    int d, p, w, cnt, slot, bitn;
    bit act, stb, bc, fs;
    d = (m_div == 0) ? 1 : m_div;
    p = (m_per == 0) ? 1 : m_per;
    w = (m_sh || m_wid >= p) ? p - 1 : m_wid;
    cnt  = k % (d + 1);
    slot = k / (d + 1);
    bitn = slot % (p + 1);
    act  = (bitn <= w);
    stb  = (cnt == 0);
    bc   = (cnt > d / 2) ^ m_ci;
    fs   = act ? m_fi : ~m_fi;
    return {28'd0, stb, bc, fs, act};
  endfunction

  function automatic int idle_vec();
    return {28'd0, 1'b0, m_ci, ~m_fi, 1'b0};
  endfunction

  task automatic configure(int dv, int pr, int wd, bit sh, bit ms, bit ci, bit fi);
    @(negedge clk);
    en = 1'b0;
    cfg_div = dv[7:0]; cfg_per = pr[7:0]; cfg_wid = wd[7:0];
    cfg_short = sh; cfg_master = ms; cfg_clk_inv = ci; cfg_fs_inv = fi;
    m_div = dv; m_per = pr; m_wid = wd; m_sh = sh; m_ci = ci; m_fi = fi;
    repeat (3) @(negedge clk);
  endtask

  // run n cycles starting at model cycle k0; enable if start set
  task automatic run_cmp(string req, bit start, int k0, int n);
    if (start) en = 1'b1;
    for (int k = k0; k < k0 + n; k++) begin
      @(posedge clk); @(negedge clk);
      chk(req, obs(), exp_vec(k));
    end
  endtask

  task automatic t_reset();
    chk("R7 reset oe", {30'd0, bclk_oe, fsync_oe}, 0);
    chk("R8 reset idle", obs(), 32'h2);
  endtask

  task automatic t_basic();
    configure(3, 7, 3, 0, 1, 0, 0);
    chk("R7 master oe", {30'd0, bclk_oe, fsync_oe}, 3);
    chk("R8 idle before enable", obs(), idle_vec());
    run_cmp("R1 R3 basic", 1, 0, 64);
  endtask

  task automatic t_div_zero();
    configure(0, 3, 1, 0, 1, 0, 0);
    run_cmp("R2 div zero", 1, 0, 24);
  endtask

  task automatic t_odd_ratio();
    configure(2, 5, 0, 0, 1, 0, 0);
    run_cmp("R1 odd ratio", 1, 0, 40);
  endtask

  task automatic t_clamp();
    configure(1, 4, 9, 0, 1, 0, 0);
    run_cmp("R4 width clamp", 1, 0, 30);
    configure(1, 0, 0, 0, 1, 0, 0);
    run_cmp("R4 period zero", 1, 0, 16);
  endtask

  task automatic t_short();
    configure(1, 6, 2, 1, 1, 0, 0);
    run_cmp("R5 short pulse", 1, 0, 30);
  endtask

  task automatic t_polarity();
    for (int c = 0; c < 4; c++) begin
      configure(3, 3, 1, 0, 1, c[0], c[1]);
      chk("R6 idle polarity", obs(), idle_vec());
      run_cmp("R6 polarity", 1, 0, 32);
    end
  endtask

  task automatic t_frozen_cfg();
    configure(1, 3, 1, 0, 1, 0, 0);
    run_cmp("R8 before change", 1, 0, 10);
    cfg_div = 8'd5; cfg_per = 8'd9; cfg_clk_inv = 1'b1; cfg_fs_inv = 1'b1;
    run_cmp("R8 change ignored", 0, 10, 30);
  endtask

  task automatic t_restart();
    configure(2, 4, 1, 0, 1, 0, 0);
    run_cmp("R9 first run", 1, 0, 17);
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 idle after disable", obs(), idle_vec());
    run_cmp("R9 restart at slot 0", 1, 0, 20);
  endtask

  task automatic t_slave();
    for (int c = 0; c < 2; c++) begin
      configure(3, 3, 1, 0, 0, c[0], c[0]);
      bclk_i  = 1'b1 ^ c[0];
      fsync_i = ~c[0];
      en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 slave oe", {30'd0, bclk_oe, fsync_oe}, 0);
      chk("R10 quiet", {30'd0, slot_stb, frame_act}, 0);
      bclk_i  = c[0];        // launch edge
      fsync_i = c[0];        // active level
      @(posedge clk); @(negedge clk);
      chk("R10 one cycle after edge", {30'd0, slot_stb, frame_act}, 0);
      @(posedge clk); @(negedge clk);
      chk("R10 strobe and frame", {30'd0, slot_stb, frame_act}, 3);
      @(posedge clk); @(negedge clk);
      chk("R10 strobe single", {30'd0, slot_stb, frame_act}, 1);
      bclk_i = 1'b1 ^ c[0];  // capture edge: no strobe
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); @(negedge clk);
        chk("R10 no strobe on capture edge", {31'd0, slot_stb}, 0);
        chk("R7 slave pins idle", {30'd0, bclk_o, fsync_o}, {30'd0, c[0], ~c[0]});
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    end
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    cfg_div = '0; cfg_per = '0; cfg_wid = '0;
    cfg_short = 0; cfg_master = 0; cfg_clk_inv = 0; cfg_fs_inv = 0;
    bclk_i = 1'b0; fsync_i = 1'b1;
    m_div = 0; m_per = 0; m_wid = 0; m_sh = 0; m_ci = 0; m_fi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_div_zero();
    t_odd_ratio();
    t_clamp();
    t_short();
    t_polarity();
    t_frozen_cfg();
    t_restart();
    t_slave();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule